// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked system to an external asynchronous static RAM of 512K bytes: 19 address lines and 8 data lines that carry both directions. The system hands it one read or one write at a time over a valid/ready handshake. The controller then drives the active-low chip select, write enable and output enable strobes. It also controls the drive enable of the shared data lines. Read data comes back with a single-cycle response pulse. The pad's tri-state buffer lives outside the block, so the bus appears as a separate output value, drive enable and input value.

All memory timing is given in picoseconds as parameters, together with the clock period. The block rounds each limit up to whole clock cycles: the access wait, the write pulse and the bus turnaround. A write always keeps output enable high, so the shorter of the two write pulse limits applies. After every read, the controller waits out the memory's release time before it drives the bus again. Write data is put on the bus one cycle before write enable falls and stays one cycle after write enable rises.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is active, and directly after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` and `rsp_valid` are 0. Once reset is released, `req_ready` is 1.
- R2: An accepted read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles. RD_CYC is the access time divided by the clock period, rounded up (3 at the default parameters).
- R3: Each read returns one `rsp_valid` pulse, exactly one cycle wide. It comes RD_CYC+1 clock edges after the accepting edge. `rsp_rdata` carries the byte present on `mem_dq_in` during the last access cycle.
- R4: A write drives `mem_we_n` low for exactly WP_CYC cycles (2 at the defaults). Whenever `mem_we_n` is 0, `mem_cs_n` is 0 and `mem_oe_n` is 1.
- R5: `mem_dq_oe` is 1 in the cycle before `mem_we_n` falls, throughout the low pulse, and in the one cycle after it rises. It is 0 in the cycle after that. The stored byte equals the write request's data.
- R6: While `mem_cs_n` is 0, `mem_addr` equals the accepted request's address. While `mem_dq_oe` is 1, `mem_dq_out` equals the accepted write data.
- R7: `req_ready` is 1 only while no access or turnaround is in progress. A request held while the block is busy is accepted only when the block returns to idle. A read followed at once by a write is accepted RD_CYC+TA_CYC+1 edges apart. A write followed at once by a read is accepted WP_CYC+3 edges apart.
- R8: `mem_dq_oe` is never 1 while the memory may be driving. After a read releases `mem_oe_n`, at least TA_CYC cycles pass (2 at the defaults) before the controller drives the bus.
- R9: Reset asserted in the middle of a write immediately forces all strobes inactive and releases the bus. After reset the block accepts and completes new requests correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | 19 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Byte read from memory |
| mem_addr | output | 19 | Address lines to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the shared data lines |
| mem_dq_oe | output | 1 | Drive enable for the shared data lines |
| mem_dq_in | input | 8 | Value seen on the shared data lines |

## Verification
Two things can coincide in one cycle. One is the end of a read: its data capture, response pulse and bus release. The other is a queued request wanting the bus, above all a write that would start driving. The bench provokes this by keeping a write's valid asserted straight after a read is accepted, and also the reverse, a read waiting behind a write. It judges the result from the exact acceptance edge of the second request. A memory model that keeps its drivers on for the release time reports any cycle where both sides drive. The read's returned byte is also checked, so it must not be disturbed by the waiting request.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_ACC   = 3'd1,
      ST_RD_TA    = 3'd2,
      ST_WR_SET   = 3'd3,
      ST_WR_PULSE = 3'd4,
      ST_WR_HOLD  = 3'd5
   } asram_state_e;

   typedef struct packed {
      logic cs_n;
      logic we_n;
      logic oe_n;
      logic drive;
   } asram_pins_t;

   localparam asram_pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

   // whole clock cycles covering a time limit, never fewer than one
   function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
      int unsigned c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

   // strobe pattern belonging to each sequencer state
   function automatic asram_pins_t pins_for(input asram_state_e st);
      asram_pins_t p;
      p = PINS_IDLE;
      case (st)
         ST_RD_ACC:   begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
         ST_WR_SET:   begin p.cs_n = 1'b0; p.drive = 1'b1; end
         ST_WR_PULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
         ST_WR_HOLD:  begin p.cs_n = 1'b0; p.drive = 1'b1; end
         default:     p = PINS_IDLE;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R2
   tmr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned CNT_W  = 2,
   parameter int unsigned RD_CYC = 3,
   parameter int unsigned WP_CYC = 2,
   parameter int unsigned TA_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_fire,
   input  logic             req_write,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             capture,
   output logic             idle,
   output asram_pins_t      pins
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

   asram_state_e state_q, state_d;
   asram_pins_t  pins_q;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_fire) begin
               if (req_write) begin
                  state_d = ST_WR_SET;
               end else begin
                  state_d  = ST_RD_ACC;
                  tmr_load = 1'b1;
                  tmr_val  = RD_LD;
               end
            end
         end
         ST_RD_ACC: begin
            if (tmr_expired) begin
               capture  = 1'b1;
               state_d  = ST_RD_TA;
               tmr_load = 1'b1;
               tmr_val  = TA_LD;
            end
         end
         ST_RD_TA: begin
            if (tmr_expired) state_d = ST_IDLE;
         end
         ST_WR_SET: begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = WP_LD;
         end
         ST_WR_PULSE: begin
            if (tmr_expired) state_d = ST_WR_HOLD;
         end
         ST_WR_HOLD: begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pins_q  <= PINS_IDLE;
      end else begin
         state_q <= state_d;
         pins_q  <= pins_for(state_d);
      end
   end

   assign idle = (state_q == ST_IDLE);
   assign pins = pins_q;

   // R3
   rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (!pins_q.cs_n && !pins_q.oe_n && pins_q.we_n));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (pins_q.cs_n && !pins_q.drive));

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (req_fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_data <= dq_in;
      end
   end

   // R3
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W        = 19,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_PS = 4000,
   parameter int unsigned T_ACCESS_PS   = 10000,
   parameter int unsigned T_WPULSE_PS   = 7000,
   parameter int unsigned T_DSETUP_PS   = 5000,
   parameter int unsigned T_RELEASE_PS  = 5000,
   parameter int unsigned T_WCYCLE_PS   = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned RD_CYC = cycles_for(T_ACCESS_PS, CLK_PERIOD_PS);
   localparam int unsigned WP_CYC = cycles_for(T_WPULSE_PS, CLK_PERIOD_PS);
   localparam int unsigned TA_CYC = cycles_for(T_RELEASE_PS, CLK_PERIOD_PS);
   localparam int unsigned MAX_CYC = (RD_CYC > WP_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                                      : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
   localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);
   localparam int unsigned HZ_W   = $clog2(TA_CYC + 1);
   localparam int unsigned WE_W   = $clog2(WP_CYC + 2);
   localparam logic [HZ_W-1:0] HZ_SAT = HZ_W'(TA_CYC);
   localparam logic [WE_W-1:0] WE_LEN = WE_W'(WP_CYC);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("asram_ctrl: address and data widths must be positive");
   end
   if (CLK_PERIOD_PS == 0) begin : g_bad_clock
      $error("asram_ctrl: clock period must be non-zero");
   end
   if (T_DSETUP_PS > (WP_CYC + 1) * CLK_PERIOD_PS) begin : g_bad_setup
      $error("asram_ctrl: write data setup cannot be met");
   end
   if (T_WCYCLE_PS > (WP_CYC + 2) * CLK_PERIOD_PS) begin : g_bad_wcycle
      $error("asram_ctrl: write cycle time cannot be met");
   end

   logic             req_fire;
   logic             idle;
   logic             capture;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   asram_pins_t      pins;

   assign req_ready = idle;
   assign req_fire  = req_valid && idle;

   asram_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   asram_seq #(
      .CNT_W  (CNT_W),
      .RD_CYC (RD_CYC),
      .WP_CYC (WP_CYC),
      .TA_CYC (TA_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_fire    (req_fire),
      .req_write   (req_write),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .capture     (capture),
      .idle        (idle),
      .pins        (pins)
   );

   asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .capture   (capture),
      .dq_in     (mem_dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_rdata)
   );

   assign mem_cs_n  = pins.cs_n;
   assign mem_we_n  = pins.we_n;
   assign mem_oe_n  = pins.oe_n;
   assign mem_dq_oe = pins.drive;

   // ---------------- checks on the pin behaviour ----------------
   logic [HZ_W-1:0] hz_cnt;
   logic [WE_W-1:0] we_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hz_cnt <= HZ_SAT;
         we_cnt <= '0;
      end else begin
         if (!mem_cs_n && !mem_oe_n && mem_we_n) hz_cnt <= '0;
         else if (hz_cnt != HZ_SAT)               hz_cnt <= hz_cnt + 1'b1;
         if (mem_we_n)            we_cnt <= '0;
         else if (we_cnt != '1)   we_cnt <= we_cnt + 1'b1;
      end
   end

   // R4
   oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_cs_n));

   // R4
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_cnt == WE_LEN));

   // R5
   drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   // R5
   drive_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(mem_dq_oe));

   // R6
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   // R8
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && (hz_cnt == HZ_SAT)));

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

   localparam int RD_CYC = 3;
   localparam int WP_CYC = 2;
   localparam int TA_CYC = 2;

   // vector: [27] write, [26:8] address, [7:0] write data or expected read data
   localparam logic [27:0] VEC [10] = '{
      {1'b1, 19'h7FFFF, 8'hA5},
      {1'b1, 19'h00000, 8'h5A},
      {1'b0, 19'h7FFFF, 8'hA5},
      {1'b0, 19'h00000, 8'h5A},
      {1'b1, 19'h12345, 8'hFF},
      {1'b0, 19'h12345, 8'hFF},
      {1'b0, 19'h00011, 8'h2D},
      {1'b1, 19'h00011, 8'h00},
      {1'b0, 19'h00011, 8'h00},
      {1'b0, 19'h4000A, 8'h36}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [18:0] req_addr;
   logic [7:0]  req_wdata;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [18:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out, mem_dq_in;

   always #2 clk = ~clk;

   asram_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] mem [64];
   logic       win_prev;
   logic [5:0] win_idx;
   logic [7:0] win_data;
   logic       mem_drv;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'h3C;
      win_prev = 1'b0;
   end

   assign mem_drv   = !mem_cs_n && !mem_oe_n && mem_we_n;
   assign mem_dq_in = mem_drv ? mem[mem_addr[5:0]] : (mem_dq_oe ? mem_dq_out : 8'hEE);

   // the write lands when the chip-select/write-enable overlap ends
   always @(posedge clk) begin
      if (!mem_cs_n && !mem_we_n) begin
         win_prev <= 1'b1;
         win_idx  <= mem_addr[5:0];
         win_data <= mem_dq_oe ? mem_dq_out : 8'hXX;
      end else begin
         if (win_prev) mem[win_idx] <= win_data;
         win_prev <= 1'b0;
      end
   end

   // ---------------- monitors ----------------
   int          cyc = 0;
   logic [18:0] acc_addr;
   logic [7:0]  acc_data;
   int          last_rd_cyc, last_wr_cyc;
   int          acc_rd_q[$];
   logic [7:0]  rsp_q[$];
   int          rsp_cyc_q[$];

   always @(posedge clk) begin
      if (rst_n && req_valid && req_ready) begin
         acc_addr = req_addr;
         acc_data = req_wdata;
         if (req_write) last_wr_cyc = cyc;
         else begin
            last_rd_cyc = cyc;
            acc_rd_q.push_back(cyc);
         end
      end
      cyc = cyc + 1;
   end

   int v_addr = 0, v_oe = 0, v_wlen = 0, v_drv = 0, v_cont = 0, v_rsp = 0, v_rdy = 0;
   int n_wpulse = 0, we_lo = 0, hz_since = 7;
   bit prev_we = 1, prev_oe = 0, hold_chk = 0, prev_rsp = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_we = 1; prev_oe = 0; we_lo = 0; hold_chk = 0; hz_since = 7; prev_rsp = 0;
      end else begin
         if (!mem_cs_n && mem_addr !== acc_addr) v_addr++;
         if (mem_dq_oe && mem_dq_out !== acc_data) v_addr++;
         if (!mem_we_n && (mem_oe_n !== 1'b1 || mem_cs_n !== 1'b0)) v_oe++;
         if (!mem_we_n && !mem_dq_oe) v_drv++;
         if (!mem_we_n && prev_we && !prev_oe) v_drv++;
         if (hold_chk && mem_dq_oe) v_drv++;
         hold_chk = 0;
         if (mem_we_n && !prev_we) begin
            n_wpulse++;
            if (we_lo != WP_CYC) v_wlen++;
            if (!mem_dq_oe) v_drv++;
            hold_chk = 1;
         end
         we_lo = mem_we_n ? 0 : we_lo + 1;
         if (mem_dq_oe && (mem_drv || hz_since < TA_CYC)) v_cont++;
         hz_since = mem_drv ? 0 : ((hz_since < 7) ? hz_since + 1 : 7);
         if (req_ready && (!mem_cs_n || !mem_oe_n || mem_dq_oe)) v_rdy++;
         if (rsp_valid) begin
            if (prev_rsp) v_rsp++;
            rsp_q.push_back(rsp_rdata);
            rsp_cyc_q.push_back(cyc);
         end
         prev_rsp = rsp_valid;
         prev_we  = mem_we_n;
         prev_oe  = mem_dq_oe;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic issue(input logic wr, input logic [18:0] a, input logic [7:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic get_rsp(output logic [7:0] data, output int lat, output bit got);
      int n = 0;
      while (rsp_q.size() == 0 && n < 50) begin
         @(negedge clk);
         n++;
      end
      got = (rsp_q.size() != 0);
      data = 8'h00; lat = -1;
      if (got) begin
         data = rsp_q.pop_front();
         lat  = rsp_cyc_q.pop_front() - acc_rd_q.pop_front();
      end
   endtask

   task automatic read_and_check(input logic [18:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] d; int lat; bit got;
      issue(1'b0, a, 8'h00);
      get_rsp(d, lat, got);
      check(got && d == exp, {tag, " read data"}, d, exp);
      check(lat == RD_CYC + 1, "R2 read latency", lat, RD_CYC + 1);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [7:0] d; int lat; bit got;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid} == 5'b11100,
            "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110,
            "R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

      // vector table
      for (int i = 0; i < 10; i++) begin
         if (VEC[i][27]) issue(1'b1, VEC[i][26:8], VEC[i][7:0]);
         else            read_and_check(VEC[i][26:8], VEC[i][7:0], "R3 vector");
      end

      // read then write held waiting: collision of read end and queued write (R7, R8)
      issue(1'b0, 19'h00011, 8'h00);
      check(req_ready == 1'b0, "R7 busy after read accept", req_ready, 0);
      issue(1'b1, 19'h0002A, 8'hC3);
      get_rsp(d, lat, got);
      check(got && d == 8'h00, "R3 read data next to queued write", d, 8'h00);
      check(last_wr_cyc - last_rd_cyc == RD_CYC + TA_CYC + 1, "R7 read-to-write acceptance gap",
            last_wr_cyc - last_rd_cyc, RD_CYC + TA_CYC + 1);
      read_and_check(19'h0002A, 8'hC3, "R5 write after turnaround");

      // write then read held waiting (R7, R5)
      issue(1'b1, 19'h00015, 8'h81);
      check(req_ready == 1'b0, "R7 busy after write accept", req_ready, 0);
      issue(1'b0, 19'h00015, 8'h00);
      get_rsp(d, lat, got);
      check(got && d == 8'h81, "R5 read right after write", d, 8'h81);
      check(last_rd_cyc - last_wr_cyc == WP_CYC + 3, "R7 write-to-read acceptance gap",
            last_rd_cyc - last_wr_cyc, WP_CYC + 3);

      // reset in the middle of a write pulse (R9)
      req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00020; req_wdata = 8'h77;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (mem_we_n) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110, "R9 strobes on reset mid-write",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      @(negedge clk);
      rst_n = 1'b1;
      acc_rd_q.delete(); rsp_q.delete(); rsp_cyc_q.delete();
      @(negedge clk);
      check(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
      read_and_check(19'h7FFFF, 8'hA5, "R9 read after reset");

      repeat (4) @(negedge clk);
      // monitor verdicts
      check(n_wpulse > 0, "R4 write pulses seen", n_wpulse, 1);
      check(v_wlen == 0, "R4 write pulse width", v_wlen, 0);
      check(v_oe == 0, "R4 output enable high in write", v_oe, 0);
      check(v_drv == 0, "R5 data drive window", v_drv, 0);
      check(v_addr == 0, "R6 address and data held", v_addr, 0);
      check(v_rdy == 0, "R7 ready only when idle", v_rdy, 0);
      check(v_cont == 0, "R8 bus contention", v_cont, 0);
      check(v_rsp == 0, "R3 single-cycle response", v_rsp, 0);
      check(rsp_q.size() == 0, "R3 no stray responses", rsp_q.size(), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule